// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps time of day and calendar date in seven byte-wide registers, all in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year (2000 to 2099). It watches a slow timebase input `tick`, nominally 1 Hz. It advances the whole clock by one second each time that input goes from high to low, and carries from seconds up through the year. The month length follows the month and the leap year.

The hours register holds two layouts, and bit 6 of the register picks between them. One is a 24-hour count. The other is a 12-hour count with an afternoon flag. Bit 7 of the seconds register stops the clock while it is set. Software-style initialisation is done through per-register load strobes that share one data byte. The block has a synchronous reset and runs entirely in the `clk` domain. The `tick` input must already be synchronous to `clk`.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After a synchronous reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour layout), weekday 0x01, date 0x01, month 0x01, year 0x00.
- R2: The clock advances by exactly one second at the first `clk` rising edge where `tick` is sampled low after being sampled high. A rising `tick` and a steady `tick` leave all registers unchanged.
- R3: Seconds and minutes count 0x00 to 0x59 in BCD. Seconds wrap to 0x00 and carry into minutes, and minutes wrap to 0x00 and carry into hours.
- R4: With hours bit 6 = 0 (24-hour layout), bits 5:0 count 0x00 to 0x23, and bit 5 is the twenties digit. The step from 0x23 goes to 0x00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour layout), bits 4:0 run 12, 01 … 11 and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12. The day advances only on the step from 11 PM to 12 AM.
- R6: The weekday counts 0x01 to 0x07 and returns to 0x01 on each day advance from 0x07.
- R7: The date wraps to 0x01 after day 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after 0x30 in months 04, 06, 09 and 11. In month 02 it wraps after 0x29 when the year value is divisible by 4, and after 0x28 otherwise. Each wrap advances the month.
- R8: The month counts 0x01 to 0x12 and wraps to 0x01, which advances the year. The year counts 0x00 to 0x99 and wraps to 0x00.
- R9: While seconds bit 7 is 1, no register advances on a falling `tick`. Clearing the bit resumes counting.
- R10: `loadEn` bit i writes `loadData` into register i at the next `clk` edge. The bit order is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, and several bits may be set together. Any load in a cycle discards a `tick` fall seen in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 Hz timebase, synchronous to clk; a high-to-low change advances the clock |
| loadEn | input | 7 | Per-register load strobes (bit order in R10) |
| loadData | input | 8 | BCD byte written by the load strobes |
| seconds | output | 8 | Bit 7 halt flag, bits 6:0 BCD seconds |
| minutes | output | 8 | BCD minutes |
| hours | output | 8 | Bit 6 layout select, bit 5 PM or twenties digit, rest BCD hours |
| weekday | output | 8 | Day of week 1..7 |
| date | output | 8 | BCD day of month |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year 00..99 |

## Verification
The edge detector holds one register, so a falling `tick` that is presented before a `clk` rising edge shows in the outputs just after that same edge. A load also appears after the single edge that samples it. The bench changes `tick`, `loadEn` and `loadData` only on falling `clk` edges and samples the outputs on the following falling edge, half a period after the one edge that matters. The intermediate sample taken after `tick` rises confirms that nothing has moved in that cycle.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 7;

  localparam int SEC_I   = 0;
  localparam int MIN_I   = 1;
  localparam int HOUR_I  = 2;
  localparam int DOW_I   = 3;
  localparam int DATE_I  = 4;
  localparam int MONTH_I = 5;
  localparam int YEAR_I  = 6;

  // control -> datapath: per-register load, advance and wrap strobes
  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic [NUM_REGS-1:0] step;
    logic [NUM_REGS-1:0] wrap;
  } calStrobe_t;

  // value after reset, also the value a field wraps back to
  function automatic logic [REG_W-1:0] baseVal(input int idx);
    if (idx == DOW_I || idx == DATE_I || idx == MONTH_I) return 8'h01;
    return 8'h00;
  endfunction

  // two-digit BCD increment (caller guarantees no overflow past 99)
  function automatic logic [REG_W-1:0] bcdInc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/clk_cal_ctrl.sv
module clk_cal_ctrl
  import clk_cal_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  logic [NUM_REGS-1:0]            loadEn,
  input  logic [NUM_REGS-1:0][REG_W-1:0] curRegs,
  output calStrobe_t                     strobe
);

  logic tickPrev;
  logic tickFall;
  logic advance;
  logic is12h;
  logic midnight;
  logic dayStep;
  logic [3:0] leapSum;
  logic isLeap;
  logic [REG_W-1:0] lastDate;

  always_ff @(posedge clk) begin
    if (rst) tickPrev <= 1'b0;
    else     tickPrev <= tick;
  end

  assign tickFall = tickPrev & ~tick;
  assign advance  = tickFall & ~curRegs[SEC_I][7] & ~(|loadEn);

  assign is12h    = curRegs[HOUR_I][6];
  assign midnight = is12h ? (curRegs[HOUR_I][5] && curRegs[HOUR_I][4:0] == 5'h11)
                          : (curRegs[HOUR_I][5:0] == 6'h23);

  // year divisible by 4: (2*tensLsb + ones) mod 4 == 0
  assign leapSum = curRegs[YEAR_I][3:0] + {2'b00, curRegs[YEAR_I][4], 1'b0};
  assign isLeap  = (leapSum[1:0] == 2'b00);

  always_comb begin
    unique case (curRegs[MONTH_I])
      8'h02:                      lastDate = isLeap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lastDate = 8'h30;
      default:                    lastDate = 8'h31;
    endcase
  end

  always_comb begin
    strobe.load = loadEn;

    strobe.wrap[SEC_I]   = (curRegs[SEC_I][6:0] == 7'h59);
    strobe.wrap[MIN_I]   = (curRegs[MIN_I] == 8'h59);
    strobe.wrap[HOUR_I]  = is12h ? (curRegs[HOUR_I][4:0] == 5'h12)
                                 : (curRegs[HOUR_I][5:0] == 6'h23);
    strobe.wrap[DOW_I]   = (curRegs[DOW_I] == 8'h07);
    strobe.wrap[DATE_I]  = (curRegs[DATE_I] == lastDate);
    strobe.wrap[MONTH_I] = (curRegs[MONTH_I] == 8'h12);
    strobe.wrap[YEAR_I]  = (curRegs[YEAR_I] == 8'h99);

    strobe.step[SEC_I]   = advance;
    strobe.step[MIN_I]   = strobe.step[SEC_I] & strobe.wrap[SEC_I];
    strobe.step[HOUR_I]  = strobe.step[MIN_I] & strobe.wrap[MIN_I];
    dayStep              = strobe.step[HOUR_I] & midnight;
    strobe.step[DOW_I]   = dayStep;
    strobe.step[DATE_I]  = dayStep;
    strobe.step[MONTH_I] = dayStep & strobe.wrap[DATE_I];
    strobe.step[YEAR_I]  = strobe.step[MONTH_I] & strobe.wrap[MONTH_I];
  end

  // R2: a rising timebase never advances the clock
  a_r2_no_step_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tick) |-> !strobe.step[SEC_I]);

  // R10: a load in the cycle drops the advance
  a_r10_load_beats_tick: assert property (@(posedge clk) disable iff (rst)
    (|loadEn) |-> (strobe.step == '0));

endmodule

// File: rtl/clk_cal_datapath.sv
module clk_cal_datapath
  import clk_cal_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  calStrobe_t                     strobe,
  input  logic [REG_W-1:0]               loadData,
  output logic [NUM_REGS-1:0][REG_W-1:0] curRegs
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] regQ;
    logic [REG_W-1:0] nextVal;

    if (i == HOUR_I) begin : g_hour
      logic [REG_W-1:0] low12Inc;
      logic             pmNext;
      always_comb begin
        low12Inc = bcdInc({3'b000, regQ[4:0]});
        pmNext   = (low12Inc[4:0] == 5'h12) ? ~regQ[5] : regQ[5];
        if (!regQ[6])
          nextVal = strobe.wrap[i] ? 8'h00 : bcdInc({2'b00, regQ[5:0]});
        else if (strobe.wrap[i])
          nextVal = {2'b01, regQ[5], 5'h01};
        else
          nextVal = {2'b01, pmNext, low12Inc[4:0]};
      end
    end else begin : g_plain
      always_comb
        nextVal = strobe.wrap[i] ? baseVal(i) : bcdInc({1'b0, regQ[6:0]});
    end

    always_ff @(posedge clk) begin
      if (rst)                 regQ <= baseVal(i);
      else if (strobe.load[i]) regQ <= loadData;
      else if (strobe.step[i]) regQ <= nextVal;
    end

    assign curRegs[i] = regQ;

    // R10: a strobed register holds the load byte one edge later
    a_r10_load_lands: assert property (@(posedge clk) disable iff (rst)
      strobe.load[i] |=> (regQ == $past(loadData)));
  end

  // R9: halted and not loaded -> nothing moves
  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (curRegs[SEC_I][7] && strobe.load == '0) |=> $stable(curRegs));

  // R3: seconds roll 59 -> 00 and minutes move with them
  a_r3_sec_carry: assert property (@(posedge clk) disable iff (rst)
    (curRegs[SEC_I] == 8'h59 && strobe.step[SEC_I] && strobe.load == '0)
    |=> (curRegs[SEC_I] == 8'h00 && curRegs[MIN_I] != $past(curRegs[MIN_I])));

  // R4: 24-hour layout wraps 23 -> 00
  a_r4_hour24_wrap: assert property (@(posedge clk) disable iff (rst)
    (curRegs[HOUR_I] == 8'h23 && strobe.step[HOUR_I] && strobe.load == '0)
    |=> (curRegs[HOUR_I] == 8'h00));

  // R5: 12-hour layout flips PM on 11 -> 12
  a_r5_pm_toggle: assert property (@(posedge clk) disable iff (rst)
    (curRegs[HOUR_I][6] && curRegs[HOUR_I][4:0] == 5'h11 && strobe.step[HOUR_I] && strobe.load == '0)
    |=> (curRegs[HOUR_I][4:0] == 5'h12 && curRegs[HOUR_I][5] != $past(curRegs[HOUR_I][5])));

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import clk_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [NUM_REGS-1:0] loadEn,
  input  logic [REG_W-1:0]    loadData,
  output logic [REG_W-1:0]    seconds,
  output logic [REG_W-1:0]    minutes,
  output logic [REG_W-1:0]    hours,
  output logic [REG_W-1:0]    weekday,
  output logic [REG_W-1:0]    date,
  output logic [REG_W-1:0]    month,
  output logic [REG_W-1:0]    year
);

  calStrobe_t                     strobe;
  logic [NUM_REGS-1:0][REG_W-1:0] curRegs;

  clk_cal_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .loadEn  (loadEn),
    .curRegs (curRegs),
    .strobe  (strobe)
  );

  clk_cal_datapath u_data (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .loadData (loadData),
    .curRegs  (curRegs)
  );

  assign seconds = curRegs[SEC_I];
  assign minutes = curRegs[MIN_I];
  assign hours   = curRegs[HOUR_I];
  assign weekday = curRegs[DOW_I];
  assign date    = curRegs[DATE_I];
  assign month   = curRegs[MONTH_I];
  assign year    = curRegs[YEAR_I];

endmodule

// File: tb/bcd_clock_calendar_test.sv
`timescale 1ns/1ps
module bcd_clock_calendar_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] loadEn = '0;
  logic [7:0] loadData = '0;
  logic [7:0] seconds, minutes, hours, weekday, date, month, year;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bcd_clock_calendar uut (
    .clk(clk), .rst(rst), .tick(tick), .loadEn(loadEn), .loadData(loadData),
    .seconds(seconds), .minutes(minutes), .hours(hours), .weekday(weekday),
    .date(date), .month(month), .year(year)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(input int idx, input logic [7:0] val);
    @(negedge clk);
    loadEn   = 7'(1 << idx);
    loadData = val;
    @(negedge clk);
    loadEn   = '0;
  endtask

  task automatic setAll(input logic [7:0] s, m, h, dw, dt, mo, yr);
    loadReg(6, yr); loadReg(5, mo); loadReg(4, dt);
    loadReg(3, dw); loadReg(2, h);  loadReg(1, m); loadReg(0, s);
  endtask

  // raise then drop tick; sample half a clock after the advancing edge
  task automatic tickOnce();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 seconds", seconds, 8'h00);
    check("R1 minutes", minutes, 8'h00);
    check("R1 hours",   hours,   8'h00);
    check("R1 weekday", weekday, 8'h01);
    check("R1 date",    date,    8'h01);
    check("R1 month",   month,   8'h01);
    check("R1 year",    year,    8'h00);
  endtask

  task automatic testEdge();
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    check("R2 no move on rise", seconds, 8'h00);
    @(negedge clk);
    check("R2 no move while high", seconds, 8'h00);
    tick = 1'b0;
    @(negedge clk);
    check("R2 one step on fall", seconds, 8'h01);
    repeat (3) @(negedge clk);
    check("R2 no move while low", seconds, 8'h01);
  endtask

  task automatic testSecMin();
    setAll(8'h09, 8'h10, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R3 digit carry", seconds, 8'h10);
    setAll(8'h59, 8'h59, 8'h05, 8'h02, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R3 sec wrap", seconds, 8'h00);
    check("R3 min wrap", minutes, 8'h00);
    check("R3 hour carry", hours, 8'h06);
  endtask

  task automatic testHour24();
    setAll(8'h59, 8'h59, 8'h19, 8'h02, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R4 19 to 20", hours, 8'h20);
    setAll(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h21);
    tickOnce();
    check("R4 23 to 00", hours, 8'h00);
    check("R6 weekday 7 to 1", weekday, 8'h01);
    check("R4 date advances", date, 8'h16);
  endtask

  task automatic testHour12();
    setAll(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R5 11AM to 12PM", hours, 8'h72);
    check("R5 noon keeps day", weekday, 8'h03);
    setAll(8'h59, 8'h59, 8'h72, 8'h03, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R5 12PM to 01PM", hours, 8'h61);
    setAll(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R5 11PM to 12AM", hours, 8'h52);
    check("R6 weekday 3 to 4", weekday, 8'h04);
  endtask

  task automatic monthEnd(input string tag, input logic [7:0] dt, mo, yr,
                          input logic [7:0] expDate, expMonth);
    setAll(8'h59, 8'h59, 8'h23, 8'h01, dt, mo, yr);
    tickOnce();
    check({tag, " date"}, date, expDate);
    check({tag, " month"}, month, expMonth);
  endtask

  task automatic testDates();
    monthEnd("R7 feb28 y23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    monthEnd("R7 feb28 y24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    monthEnd("R7 feb29 y00", 8'h29, 8'h02, 8'h00, 8'h01, 8'h03);
    monthEnd("R7 feb28 y12", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    monthEnd("R7 feb28 y10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
    monthEnd("R7 apr30",     8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
    monthEnd("R7 jan30",     8'h30, 8'h01, 8'h21, 8'h31, 8'h01);
    monthEnd("R7 nov30",     8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
  endtask

  task automatic testYear();
    setAll(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h45);
    tickOnce();
    check("R8 dec to jan", month, 8'h01);
    check("R8 year 45 to 46", year, 8'h46);
    setAll(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    tickOnce();
    check("R8 year 99 to 00", year, 8'h00);
    check("R8 date after new year", date, 8'h01);
  endtask

  task automatic testHalt();
    setAll(8'hB0, 8'h20, 8'h10, 8'h02, 8'h10, 8'h06, 8'h21);
    tickOnce();
    check("R9 halted seconds", seconds, 8'hB0);
    check("R9 halted minutes", minutes, 8'h20);
    loadReg(0, 8'h30);
    tickOnce();
    check("R9 resumed", seconds, 8'h31);
  endtask

  task automatic testLoad();
    setAll(8'h20, 8'h10, 8'h10, 8'h02, 8'h10, 8'h06, 8'h21);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; loadEn = 7'b0000010; loadData = 8'h33;
    @(negedge clk); loadEn = '0;
    check("R10 tick dropped under load", seconds, 8'h20);
    check("R10 minutes loaded", minutes, 8'h33);
    @(negedge clk); loadEn = 7'b0011000; loadData = 8'h05;
    @(negedge clk); loadEn = '0;
    check("R10 multi load weekday", weekday, 8'h05);
    check("R10 multi load date", date, 8'h05);
    check("R10 others untouched", month, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testEdge();
    testSecMin();
    testHour24();
    testHour12();
    testDates();
    testYear();
    testHalt();
    testLoad();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule